// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on a parallel microcontroller bus in front of a flash memory model. It watches bus write cycles, each made of an address, a data byte, an active-low write strobe and two groups of sector-select lines. From these it recognises multi-byte command sequences that open with a two-write unlock pattern. Each recognised command is reported as a single-cycle pulse. With the pulse come the bank it targets (primary or secondary), the sector index taken from the select lines, and the address and data of the write that completed it. A mode output shows whether the decoder is in plain read mode, in the middle of a sequence, in identifier/protection read mode, or in bypass mode.

A write strobe is synchronised to the block clock, and its rising edge marks one write cycle. The decoder returns to read mode when a byte does not fit the sequence or when the gap between command bytes is too long. A lockout input blocks all write recognition while the supply is too low. In bypass mode the unlock writes are skipped, which shortens repeated program operations.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A sequence opens with data AAh at low address 555h, then data 55h at low address AAAh. Every address comparison uses only the low 12 bits of `addr_i`, and the upper bits are ignored.
- R2: A write cycle is the rising edge of `wr_ni`. It counts only if at least one of `psel_i`/`ssel_i` is high at that point. A write with no select high has no effect.
- R3: While `lockout_i` is high, write cycles have no effect.
- R4: `cmd_bank_o` is 0 (primary) when any `psel_i` line is high, even if `ssel_i` lines are also high. Otherwise it is 1 (secondary). `cmd_sector_o` is the lowest-numbered high line of the chosen group. Both are captured with each command pulse.
- R5: A byte that does not fit the expected sequence returns the decoder to read mode and switches bypass off. In plain read mode, any write other than AAh at 555h is ignored.
- R6: If a partial sequence sees no counted write for `TIMEOUT_CYC` clock cycles, it is discarded. The decoder returns to read mode with bypass off.
- R7: After reset the mode is read and no pulse is active. `mode_o` encodes 0 = read, 1 = sequence in progress, 2 = identifier/protection read, 3 = bypass idle.
- R8: After the unlock, command byte F0h pulses `cmd_reset_o` and switches bypass off. B0h pulses `cmd_suspend_o` and 30h pulses `cmd_resume_o`. A0h arms a program: the next counted write pulses `cmd_prog_o`, with `cmd_addr_o`/`cmd_data_o` equal to that write. Every pulse lasts one cycle, and at most one pulse is active at a time.
- R9: Command byte 80h starts erase setup. It must be followed by AAh at 555h, then 55h at AAAh, then either 10h at 555h (pulse `cmd_chip_erase_o`) or 30h at any address (pulse `cmd_sect_erase_o`). Anything else returns to read mode.
- R10: Command byte 90h at low address 555h pulses `cmd_read_id_o`, but only for the primary bank. Aimed at the secondary bank it is invalid and returns to read mode. Command byte 90h at any other address pulses `cmd_read_prot_o` for either bank. Both enter mode 2. Any counted write in mode 2 returns to read mode, and F0h also pulses `cmd_reset_o`.
- R11: Command byte 20h enters bypass (mode 3). In bypass, command bytes are taken with no unlock writes, and 80h is followed directly by the erase confirm byte. Bypass remains on after a completed program, erase, suspend or resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lockout_i | input | 1 | Low-supply lockout; blocks write recognition |
| wr_ni | input | 1 | Active-low bus write strobe (asynchronous) |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | 8 | Bus write data |
| psel_i | input | PRI_W | Primary-bank sector selects |
| ssel_i | input | SEC_W | Secondary-bank sector selects |
| cmd_reset_o | output | 1 | Reset-to-read command pulse |
| cmd_prog_o | output | 1 | Program-byte pulse |
| cmd_chip_erase_o | output | 1 | Chip erase pulse |
| cmd_sect_erase_o | output | 1 | Sector erase pulse |
| cmd_suspend_o | output | 1 | Erase suspend pulse |
| cmd_resume_o | output | 1 | Erase resume pulse |
| cmd_read_id_o | output | 1 | Identifier read pulse |
| cmd_read_prot_o | output | 1 | Protection status read pulse |
| cmd_bank_o | output | 1 | Target bank of the last command (0 primary) |
| cmd_sector_o | output | SECT_W | Sector index of the last command |
| cmd_addr_o | output | ADDR_W | Address of the write that completed the last command |
| cmd_data_o | output | 8 | Data of the write that completed the last command |
| mode_o | output | 2 | Current mode |

## Verification
The assertions assume that address, data and select lines stay stable from the fall of `wr_ni` until a few clock cycles after its rise. They also assume that strobe pulses are wider than the synchroniser. Without this, the sampled bus would not be the one the strobe framed. The stimulus meets both assumptions: it changes the bus only while the strobe is high and idle, keeps the strobe low for two clocks, and then waits six clocks before the next write. Gaps meant to stay within the timeout are kept well below `TIMEOUT_CYC`. Gaps meant to exceed it are kept well above it, so that a one-cycle difference in where counting starts cannot change the result.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam logic [7:0] BYTE_UNLK_A  = 8'hAA;
   localparam logic [7:0] BYTE_UNLK_B  = 8'h55;
   localparam logic [7:0] BYTE_RESET   = 8'hF0;
   localparam logic [7:0] BYTE_PROG    = 8'hA0;
   localparam logic [7:0] BYTE_ERASE   = 8'h80;
   localparam logic [7:0] BYTE_IDENT   = 8'h90;
   localparam logic [7:0] BYTE_SUSPEND = 8'hB0;
   localparam logic [7:0] BYTE_RESUME  = 8'h30;
   localparam logic [7:0] BYTE_BYPASS  = 8'h20;
   localparam logic [7:0] BYTE_CHIP    = 8'h10;
   localparam logic [7:0] BYTE_SECTOR  = 8'h30;

   localparam logic [11:0] LOW_ADDR_A = 12'h555;
   localparam logic [11:0] LOW_ADDR_B = 12'hAAA;

   typedef enum logic [1:0] {
      MODE_READ = 2'd0,
      MODE_SEQ  = 2'd1,
      MODE_ID   = 2'd2,
      MODE_BYP  = 2'd3
   } fmode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNL1,
      ST_UNL2,
      ST_PROG,
      ST_ERS1,
      ST_ERS2,
      ST_ERS3,
      ST_IDRD
   } fstate_e;

   typedef struct packed {
      logic reset;
      logic prog;
      logic chip_erase;
      logic sect_erase;
      logic suspend;
      logic resume;
      logic read_id;
      logic read_prot;
   } cmd_pulse_t;

endpackage

// File: rtl/fcd_wr_detect.sv
// Synchroniser plus rising-edge detector for the asynchronous write strobe.
module fcd_wr_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wr_ni,
   output logic evt_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q <= '1;
            else         sync_q <= wr_ni;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q <= '1;
            else         sync_q <= {sync_q[SYNC_STAGES-2:0], wr_ni};
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign evt_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/fcd_sel_route.sv
// Picks the target bank from the select groups and encodes the sector index.
module fcd_sel_route #(
   parameter int PRI_W  = 8,
   parameter int SEC_W  = 4,
   parameter int SECT_W = 3
) (
   input  logic [PRI_W-1:0]  psel_i,
   input  logic [SEC_W-1:0]  ssel_i,
   output logic              any_o,
   output logic              bank_o,
   output logic [SECT_W-1:0] sector_o
);
   logic [SECT_W-1:0] pri_idx;
   logic [SECT_W-1:0] sec_idx;

   always_comb begin
      pri_idx = '0;
      for (int i = PRI_W - 1; i >= 0; i--) begin
         if (psel_i[i]) pri_idx = SECT_W'(i);
      end
   end

   always_comb begin
      sec_idx = '0;
      for (int i = SEC_W - 1; i >= 0; i--) begin
         if (ssel_i[i]) sec_idx = SECT_W'(i);
      end
   end

   assign any_o    = (|psel_i) | (|ssel_i);
   assign bank_o   = ~(|psel_i);
   assign sector_o = (|psel_i) ? pri_idx : sec_idx;
endmodule

// File: rtl/fcd_timeout.sv
// Inter-byte gap counter; fires when a partial sequence sits idle too long.
module fcd_timeout #(
   parameter int TIMEOUT_CYC = 64
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic restart_i,
   output logic expire_o
);
   localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   assign expire_o = run_i & ~restart_i & (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cnt_q <= '0;
      else if (!run_i || restart_i || expire_o) cnt_q <= '0;
      else                                      cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/fcd_seq_fsm.sv
// Command sequence state machine with registered command pulses.
module fcd_seq_fsm
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int MATCH_W = 12,
   parameter int SECT_W  = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              acc_i,
   input  logic              expire_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        data_i,
   input  logic              bank_i,
   input  logic [SECT_W-1:0] sector_i,
   output cmd_pulse_t        pulse_o,
   output logic              bank_o,
   output logic [SECT_W-1:0] sector_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [7:0]        data_o,
   output fmode_e            mode_o,
   output logic              partial_o
);
   fstate_e    st_q, st_n;
   logic       byp_q, byp_n;
   cmd_pulse_t pls_n;
   logic       is_a, is_b, cmd_phase;

   assign is_a      = addr_i[MATCH_W-1:0] == MATCH_W'(LOW_ADDR_A);
   assign is_b      = addr_i[MATCH_W-1:0] == MATCH_W'(LOW_ADDR_B);
   assign cmd_phase = (st_q == ST_UNL2) || (st_q == ST_IDLE && byp_q);

   always_comb begin
      st_n  = st_q;
      byp_n = byp_q;
      pls_n = '0;
      if (expire_i) begin
         st_n  = ST_IDLE;
         byp_n = 1'b0;
      end else if (acc_i) begin
         if (cmd_phase) begin
            st_n = ST_IDLE;
            unique case (data_i)
               BYTE_RESET:   begin pls_n.reset = 1'b1; byp_n = 1'b0; end
               BYTE_PROG:    st_n = ST_PROG;
               BYTE_ERASE:   st_n = byp_q ? ST_ERS3 : ST_ERS1;
               BYTE_SUSPEND: pls_n.suspend = 1'b1;
               BYTE_RESUME:  pls_n.resume = 1'b1;
               BYTE_BYPASS:  byp_n = 1'b1;
               BYTE_IDENT: begin
                  if (!is_a) begin
                     pls_n.read_prot = 1'b1;
                     st_n = ST_IDRD;
                  end else if (!bank_i) begin
                     pls_n.read_id = 1'b1;
                     st_n = ST_IDRD;
                  end else begin
                     byp_n = 1'b0;
                  end
               end
               default:      byp_n = 1'b0;
            endcase
         end else begin
            unique case (st_q)
               ST_IDLE: if (data_i == BYTE_UNLK_A && is_a) st_n = ST_UNL1;
               ST_UNL1, ST_ERS2: begin
                  if (data_i == BYTE_UNLK_B && is_b) begin
                     st_n = (st_q == ST_UNL1) ? ST_UNL2 : ST_ERS3;
                  end else begin
                     st_n = ST_IDLE; byp_n = 1'b0;
                  end
               end
               ST_ERS1: begin
                  if (data_i == BYTE_UNLK_A && is_a) st_n = ST_ERS2;
                  else begin st_n = ST_IDLE; byp_n = 1'b0; end
               end
               ST_PROG: begin
                  pls_n.prog = 1'b1;
                  st_n = ST_IDLE;
               end
               ST_ERS3: begin
                  st_n = ST_IDLE;
                  if (data_i == BYTE_CHIP && is_a)  pls_n.chip_erase = 1'b1;
                  else if (data_i == BYTE_SECTOR)   pls_n.sect_erase = 1'b1;
                  else                              byp_n = 1'b0;
               end
               ST_IDRD: begin
                  st_n  = ST_IDLE;
                  byp_n = 1'b0;
                  if (data_i == BYTE_RESET) pls_n.reset = 1'b1;
               end
               default: begin st_n = ST_IDLE; byp_n = 1'b0; end
            endcase
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_IDLE;
         byp_q   <= 1'b0;
         pulse_o <= '0;
      end else begin
         st_q    <= st_n;
         byp_q   <= byp_n;
         pulse_o <= pls_n;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bank_o   <= 1'b0;
         sector_o <= '0;
         addr_o   <= '0;
         data_o   <= '0;
      end else if (|pls_n) begin
         bank_o   <= bank_i;
         sector_o <= sector_i;
         addr_o   <= addr_i;
         data_o   <= data_i;
      end
   end

   always_comb begin
      unique case (st_q)
         ST_IDLE: mode_o = byp_q ? MODE_BYP : MODE_READ;
         ST_IDRD: mode_o = MODE_ID;
         default: mode_o = MODE_SEQ;
      endcase
   end

   assign partial_o = (st_q != ST_IDLE) && (st_q != ST_IDRD);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int MATCH_W     = 12,
   parameter int PRI_W       = 8,
   parameter int SEC_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 64,
   localparam int SEL_MAX    = (PRI_W > SEC_W) ? PRI_W : SEC_W,
   localparam int SECT_W     = (SEL_MAX > 1) ? $clog2(SEL_MAX) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              lockout_i,
   input  logic              wr_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        data_i,
   input  logic [PRI_W-1:0]  psel_i,
   input  logic [SEC_W-1:0]  ssel_i,
   output logic              cmd_reset_o,
   output logic              cmd_prog_o,
   output logic              cmd_chip_erase_o,
   output logic              cmd_sect_erase_o,
   output logic              cmd_suspend_o,
   output logic              cmd_resume_o,
   output logic              cmd_read_id_o,
   output logic              cmd_read_prot_o,
   output logic              cmd_bank_o,
   output logic [SECT_W-1:0] cmd_sector_o,
   output logic [ADDR_W-1:0] cmd_addr_o,
   output logic [7:0]        cmd_data_o,
   output logic [1:0]        mode_o
);
   generate
      if (MATCH_W < 12 || MATCH_W > ADDR_W) begin : g_bad_match
         $error("MATCH_W must lie between 12 and ADDR_W");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 2");
      end
      if (PRI_W < 1 || SEC_W < 1) begin : g_bad_sel
         $error("each select group needs at least one line");
      end
   endgenerate

   logic              wr_evt;
   logic              any_sel;
   logic              sel_bank;
   logic [SECT_W-1:0] sel_sector;
   logic              wr_acc;
   logic              seq_partial;
   logic              seq_expire;
   cmd_pulse_t        pulses;
   fmode_e            mode_q;

   fcd_wr_detect #(.SYNC_STAGES(SYNC_STAGES)) u_wr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_ni (wr_ni),
      .evt_o (wr_evt)
   );

   fcd_sel_route #(.PRI_W(PRI_W), .SEC_W(SEC_W), .SECT_W(SECT_W)) u_route (
      .psel_i  (psel_i),
      .ssel_i  (ssel_i),
      .any_o   (any_sel),
      .bank_o  (sel_bank),
      .sector_o(sel_sector)
   );

   assign wr_acc = wr_evt & any_sel & ~lockout_i;

   fcd_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_to (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (seq_partial),
      .restart_i(wr_acc),
      .expire_o (seq_expire)
   );

   fcd_seq_fsm #(.ADDR_W(ADDR_W), .MATCH_W(MATCH_W), .SECT_W(SECT_W)) u_fsm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .acc_i    (wr_acc),
      .expire_i (seq_expire),
      .addr_i   (addr_i),
      .data_i   (data_i),
      .bank_i   (sel_bank),
      .sector_i (sel_sector),
      .pulse_o  (pulses),
      .bank_o   (cmd_bank_o),
      .sector_o (cmd_sector_o),
      .addr_o   (cmd_addr_o),
      .data_o   (cmd_data_o),
      .mode_o   (mode_q),
      .partial_o(seq_partial)
   );

   assign cmd_reset_o      = pulses.reset;
   assign cmd_prog_o       = pulses.prog;
   assign cmd_chip_erase_o = pulses.chip_erase;
   assign cmd_sect_erase_o = pulses.sect_erase;
   assign cmd_suspend_o    = pulses.suspend;
   assign cmd_resume_o     = pulses.resume;
   assign cmd_read_id_o    = pulses.read_id;
   assign cmd_read_prot_o  = pulses.read_prot;
   assign mode_o           = mode_q;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
   parameter int PRI_W       = 8,
   parameter int SEC_W       = 4,
   parameter int TIMEOUT_CYC = 64
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             lockout_i,
   input logic [PRI_W-1:0] psel_i,
   input logic [SEC_W-1:0] ssel_i,
   input logic             wr_evt,
   input logic [7:0]       pls,
   input logic             bank,
   input logic [1:0]       mode
);
   localparam logic [1:0] M_READ = 2'd0;
   localparam logic [1:0] M_SEQ  = 2'd1;
   localparam logic [1:0] M_ID   = 2'd2;

   // pls order: reset, prog, chip, sector, suspend, resume, read_id, read_prot
   logic [31:0] gap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     gap_q <= '0;
      else if (mode != M_SEQ || wr_evt) gap_q <= '0;
      else                             gap_q <= gap_q + 1;
   end

   assert_one_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(pls));

   assert_cmd_ends_seq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|pls[7:2]) |-> (mode != M_SEQ && mode != M_ID));

   assert_lockout_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lockout_i && mode == M_READ) |=> (mode == M_READ));

   assert_nosel_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (psel_i == '0 && ssel_i == '0 && mode == M_READ) |=> (mode == M_READ));

   assert_gap_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == M_SEQ) |-> (gap_q < 32'(TIMEOUT_CYC)));

   assert_id_primary_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pls[1] |-> (bank == 1'b0));

   assert_id_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pls[1] || pls[0]) |-> (mode == M_ID));
endmodule

bind flash_cmd_decoder fcd_checker #(
   .PRI_W(PRI_W), .SEC_W(SEC_W), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .lockout_i(lockout_i),
   .psel_i   (psel_i),
   .ssel_i   (ssel_i),
   .wr_evt   (wr_evt),
   .pls      (pulses),
   .bank     (cmd_bank_o),
   .mode     (mode_o)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
   localparam int TO = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lockout = 1'b0;
   logic        wr_n = 1'b1;
   logic [15:0] addr = '0;
   logic [7:0]  data = '0;
   logic [7:0]  psel = '0;
   logic [3:0]  ssel = '0;
   logic        p_reset, p_prog, p_chip, p_sect, p_susp, p_res, p_id, p_prot;
   logic        bank;
   logic [2:0]  sector;
   logic [15:0] c_addr;
   logic [7:0]  c_data;
   logic [1:0]  mode;

   always #10 clk = ~clk;

   flash_cmd_decoder #(.TIMEOUT_CYC(TO)) dut (
      .clk_i(clk), .rst_ni(rst_n), .lockout_i(lockout), .wr_ni(wr_n),
      .addr_i(addr), .data_i(data), .psel_i(psel), .ssel_i(ssel),
      .cmd_reset_o(p_reset), .cmd_prog_o(p_prog), .cmd_chip_erase_o(p_chip),
      .cmd_sect_erase_o(p_sect), .cmd_suspend_o(p_susp), .cmd_resume_o(p_res),
      .cmd_read_id_o(p_id), .cmd_read_prot_o(p_prot), .cmd_bank_o(bank),
      .cmd_sector_o(sector), .cmd_addr_o(c_addr), .cmd_data_o(c_data),
      .mode_o(mode)
   );

   int total = 0;
   int bad   = 0;
   int pcount = 0;
   int pcode  = 0;

   // pulse codes: 0 none, 1 reset, 2 prog, 3 chip, 4 sector, 5 suspend, 6 resume, 7 id, 8 prot
   always @(negedge clk) begin
      logic [7:0] v;
      v = {p_reset, p_prog, p_chip, p_sect, p_susp, p_res, p_id, p_prot};
      if (v != 8'h0) begin
         pcount = pcount + $countones(v);
         for (int k = 0; k < 8; k++) if (v[7-k]) pcode = k + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [15:0] a, input logic [7:0] d,
                        input logic [7:0] ps, input logic [3:0] ss);
      @(negedge clk);
      addr = a; data = d; psel = ps; ssel = ss; wr_n = 1'b0; pcount = 0;
      repeat (2) @(negedge clk);
      wr_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   function automatic int seen();
      return (pcount == 0) ? 0 : ((pcount > 1) ? 15 : pcode);
   endfunction

   function automatic string req_of(input int code);
      case (code)
         3, 4:    return "R9";
         7, 8:    return "R10";
         0:       return "R5";
         default: return "R8";
      endcase
   endfunction

   // vector: addr, data, psel, ssel, code, bank, sector, mode, pad
   localparam int NV = 53;
   localparam logic [47:0] VT [NV] = '{
      {16'h0555, 8'hAA, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h1AAA, 8'h55, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'hF555, 8'hA0, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h3123, 8'h5C, 8'h04, 4'h0, 4'd2, 1'b0, 3'd2, 2'd0, 2'd0},
      {16'h0555, 8'hAA, 8'h00, 4'h2, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0AAA, 8'h55, 8'h00, 4'h2, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0555, 8'h80, 8'h00, 4'h2, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h8555, 8'hAA, 8'h00, 4'h2, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h9AAA, 8'h55, 8'h00, 4'h2, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h7000, 8'h30, 8'h00, 4'h4, 4'd4, 1'b1, 3'd2, 2'd0, 2'd0},
      {16'h0555, 8'hAA, 8'h80, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0AAA, 8'h55, 8'h80, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0555, 8'h80, 8'h80, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0555, 8'hAA, 8'h80, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0AAA, 8'h55, 8'h80, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h2555, 8'h10, 8'h80, 4'h0, 4'd3, 1'b0, 3'd7, 2'd0, 2'd0},
      {16'h0555, 8'hAA, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0AAA, 8'h55, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0555, 8'hB0, 8'h02, 4'h1, 4'd5, 1'b0, 3'd1, 2'd0, 2'd0},
      {16'h0555, 8'hAA, 8'h00, 4'h8, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0AAA, 8'h55, 8'h00, 4'h8, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0444, 8'h30, 8'h00, 4'h8, 4'd6, 1'b1, 3'd3, 2'd0, 2'd0},
      {16'h0555, 8'hAA, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0AAA, 8'h55, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0555, 8'h90, 8'h01, 4'h0, 4'd7, 1'b0, 3'd0, 2'd2, 2'd0},
      {16'h0000, 8'hF0, 8'h01, 4'h0, 4'd1, 1'b0, 3'd0, 2'd0, 2'd0},
      {16'h0555, 8'hAA, 8'h00, 4'h1, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0AAA, 8'h55, 8'h00, 4'h1, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0555, 8'h90, 8'h00, 4'h1, 4'd0, 1'b0, 3'd0, 2'd0, 2'd0},
      {16'h0555, 8'hAA, 8'h00, 4'h1, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0AAA, 8'h55, 8'h00, 4'h1, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0123, 8'h90, 8'h00, 4'h1, 4'd8, 1'b1, 3'd0, 2'd2, 2'd0},
      {16'h0000, 8'hF0, 8'h00, 4'h1, 4'd1, 1'b1, 3'd0, 2'd0, 2'd0},
      {16'h0555, 8'hAA, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0AAA, 8'h56, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd0, 2'd0},
      {16'h0AAA, 8'h55, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd0, 2'd0},
      {16'h0555, 8'hAA, 8'h00, 4'h0, 4'd0, 1'b0, 3'd0, 2'd0, 2'd0},
      {16'h0555, 8'hAA, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0AAA, 8'h55, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0555, 8'h20, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd3, 2'd0},
      {16'h0000, 8'hA0, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h4567, 8'h9A, 8'h10, 4'h0, 4'd2, 1'b0, 3'd4, 2'd3, 2'd0},
      {16'h0000, 8'h80, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0555, 8'h10, 8'h01, 4'h0, 4'd3, 1'b0, 3'd0, 2'd3, 2'd0},
      {16'h0000, 8'hB0, 8'h01, 4'h0, 4'd5, 1'b0, 3'd0, 2'd3, 2'd0},
      {16'h0000, 8'h77, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd0, 2'd0},
      {16'h0000, 8'hA0, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd0, 2'd0},
      {16'h0555, 8'hAA, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0AAA, 8'h55, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0555, 8'h80, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0555, 8'hAA, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0AAA, 8'h55, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd1, 2'd0},
      {16'h0556, 8'h10, 8'h01, 4'h0, 4'd0, 1'b0, 3'd0, 2'd0, 2'd0}
   };

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R7: reset state
      repeat (3) @(negedge clk);
      chk(mode == 2'd0, "R7 mode in reset", mode, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(mode == 2'd0 && pcount == 0, "R7 mode after reset", mode, 0);

      for (int i = 0; i < NV; i++) begin
         logic [47:0] v;
         int ec;
         v  = VT[i];
         ec = int'(v[11:8]);
         do_wr(v[47:32], v[31:24], v[23:16], v[15:12]);
         chk(seen() == ec, req_of(ec), seen(), ec);
         chk(mode == v[3:2], (v[3:2] == 2'd3) ? "R11 mode" : "R7 mode", mode, v[3:2]);
         if (ec != 0) chk({bank, sector} == v[7:4], "R4 bank/sector", {bank, sector}, v[7:4]);
         if (ec == 2) chk({c_addr, c_data} == {v[47:32], v[31:24]}, "R8 program addr/data",
                          {c_addr, c_data}, {v[47:32], v[31:24]});
      end

      // R1: upper address bits ignored on both unlock writes
      do_wr(16'hF555, 8'hAA, 8'h01, 4'h0);
      do_wr(16'hEAAA, 8'h55, 8'h01, 4'h0);
      chk(mode == 2'd1, "R1 masked unlock", mode, 1);
      do_wr(16'h0000, 8'h30, 8'h01, 4'h0);
      chk(seen() == 6, "R1 command after masked unlock", seen(), 6);

      // R3: lockout blocks the unlock write
      lockout = 1'b1;
      do_wr(16'h0555, 8'hAA, 8'h01, 4'h0);
      chk(mode == 2'd0, "R3 lockout", mode, 0);
      lockout = 1'b0;

      // R6: gap longer than timeout aborts
      do_wr(16'h0555, 8'hAA, 8'h01, 4'h0);
      do_wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
      repeat (TO + 20) @(negedge clk);
      chk(mode == 2'd0, "R6 timeout to read", mode, 0);
      do_wr(16'h0555, 8'hB0, 8'h01, 4'h0);
      chk(seen() == 0, "R6 command after timeout", seen(), 0);

      // R6: gaps below timeout keep the sequence
      do_wr(16'h0555, 8'hAA, 8'h01, 4'h0);
      repeat (15) @(negedge clk);
      do_wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
      repeat (15) @(negedge clk);
      do_wr(16'h0555, 8'hB0, 8'h01, 4'h0);
      chk(seen() == 5, "R6 slow but in time", seen(), 5);

      // R6/R11: timeout inside bypass clears bypass
      do_wr(16'h0555, 8'hAA, 8'h01, 4'h0);
      do_wr(16'h0AAA, 8'h55, 8'h01, 4'h0);
      do_wr(16'h0555, 8'h20, 8'h01, 4'h0);
      chk(mode == 2'd3, "R11 bypass entered", mode, 3);
      do_wr(16'h0000, 8'hA0, 8'h01, 4'h0);
      repeat (TO + 20) @(negedge clk);
      chk(mode == 2'd0, "R6 bypass cleared by timeout", mode, 0);

      // R7: reset mid-sequence
      do_wr(16'h0555, 8'hAA, 8'h01, 4'h0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mode == 2'd0, "R7 reset mid-sequence", mode, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule